// File: doc/BRIEF.md
# Serial EEPROM Address Pointer

This block holds the current array address of a 1K x 8 serial EEPROM slave that sits on a single-wire bus. An upstream bit-level receiver has already turned the line activity into single-cycle strobes. One strobe marks a decoded command. Another marks a received address byte and carries the byte value. Further strobes mark a completed data byte, a master acknowledge, a master no-acknowledge and a standby pulse. The block follows the transaction from these strobes. It presents to the storage array the address of the next byte to read or write.

Two commands take an explicit address: random read and page write. Each sends two address bytes, most significant first. Each byte is acknowledged by the master, and the pointer takes the assembled value on the acknowledge of the second byte. The current-address read takes no address and starts from the value already held. Every data byte that the master acknowledges or no-acknowledges moves the pointer by one. Reads run through the whole array. Writes circle within the selected 16-byte page. A standby pulse in place of the acknowledge aborts the transaction without moving the pointer. The value after power-on is unknown, and a valid flag stays low until the first address load.

Top module: `eeprom_addr_ptr`

## Requirements
- R1: After reset `addr_valid` is 0. It stays 0 until the first complete address load.
- R2: After a READ (`cmd_op`=2'b01) or WRITE (`cmd_op`=2'b10) command, the block takes two address bytes, high byte first, each followed by `ev_mak`. One cycle after the MAK that follows the second byte, `arr_addr` equals the low 10 bits of {high, low} and `addr_valid` is 1. The MAK after the first address byte leaves `arr_addr` and `addr_valid` unchanged.
- R3: While a transaction is in its data phase, an `ev_data` strobe followed by `ev_mak` or `ev_nomak` advances `arr_addr` by one. The new value is visible one cycle after the acknowledge strobe.
- R4: During READ and current-address read, the advance wraps the address from 1023 to 0.
- R5: During WRITE, the advance adds one modulo 16 to bits [3:0] of `arr_addr` and keeps bits [9:4] unchanged, so the address wraps from the last byte of the page to the first byte of the same page.
- R6: An `ev_standby` after a data byte, instead of an acknowledge, leaves `arr_addr` unchanged. It ends the transaction, so a following `ev_mak` does not advance the pointer.
- R7: A current-address read (`cmd_op`=2'b11) takes no address bytes. Its data bytes advance `arr_addr` from the value it already holds, and `addr_valid` is not changed.
- R8: An `ev_nomak` ends a sequential transfer. Further `ev_data` and `ev_mak` strobes without a new command leave `arr_addr` unchanged.
- R9: Strobes that arrive outside their expected step are ignored. This covers an `ev_mak` with no byte pending, and address bytes after an unknown command code (`cmd_op`=2'b00).

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously upstream |
| ev_cmd | input | 1 | Command decoded strobe |
| cmd_op | input | 2 | Command code: 01 read, 10 write, 11 current-address read, 00 other |
| ev_addr | input | 1 | Address byte received strobe |
| byte_in | input | 8 | Value of the received address byte |
| ev_data | input | 1 | Data byte completed strobe |
| ev_mak | input | 1 | Master acknowledge strobe |
| ev_nomak | input | 1 | Master no-acknowledge strobe |
| ev_standby | input | 1 | Standby pulse strobe |
| arr_addr | output | 10 | Current array address |
| addr_valid | output | 1 | Address has been loaded since reset |

## Verification
The assertions assume that at most one event strobe is high in any cycle. They also assume that each strobe lasts exactly one cycle, since the upstream receiver reports one line event at a time. The stimulus drives every event through a task that raises a single strobe for one clock and lowers it before the next event, so the strobes never overlap. The stimulus also inserts out-of-step and aborted sequences to exercise the ignore paths. A behavioural model of the transaction steps is compared with the outputs on every clock.

// File: rtl/eeprom_ptr_pkg.sv
package eeprom_ptr_pkg;

  typedef enum logic [1:0] {
    OP_NONE  = 2'b00,
    OP_READ  = 2'b01,
    OP_WRITE = 2'b10,
    OP_CURR  = 2'b11
  } op_e;

  typedef enum logic [2:0] {
    PH_IDLE,
    PH_AHI,
    PH_AHI_ACK,
    PH_ALO,
    PH_ALO_ACK,
    PH_DATA,
    PH_DATA_ACK
  } phase_e;

endpackage

// File: rtl/ptr_seq.sv
module ptr_seq
  import eeprom_ptr_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       ev_cmd,
  input  logic [1:0] cmd_op,
  input  logic       ev_addr,
  input  logic       ev_data,
  input  logic       ev_mak,
  input  logic       ev_nomak,
  input  logic       ev_standby,
  output logic       hi_cap,
  output logic       lo_cap,
  output logic       load,
  output logic       inc,
  output logic       wr_mode
);

  phase_e phase_q, phase_d;
  logic   wr_q, wr_d;

  // next-state logic
  always_comb begin
    phase_d = phase_q;
    wr_d    = wr_q;
    hi_cap  = 1'b0;
    lo_cap  = 1'b0;
    load    = 1'b0;
    inc     = 1'b0;
    if (ev_standby) begin
      phase_d = PH_IDLE;
    end else if (ev_cmd) begin
      case (op_e'(cmd_op))
        OP_READ:  begin phase_d = PH_AHI;  wr_d = 1'b0; end
        OP_WRITE: begin phase_d = PH_AHI;  wr_d = 1'b1; end
        OP_CURR:  begin phase_d = PH_DATA; wr_d = 1'b0; end
        default:  begin phase_d = PH_IDLE; wr_d = 1'b0; end
      endcase
    end else begin
      case (phase_q)
        PH_AHI: begin
          if (ev_addr) begin
            hi_cap  = 1'b1;
            phase_d = PH_AHI_ACK;
          end else if (ev_nomak) begin
            phase_d = PH_IDLE;
          end
        end
        PH_AHI_ACK: begin
          if (ev_mak)        phase_d = PH_ALO;
          else if (ev_nomak) phase_d = PH_IDLE;
        end
        PH_ALO: begin
          if (ev_addr) begin
            lo_cap  = 1'b1;
            phase_d = PH_ALO_ACK;
          end else if (ev_nomak) begin
            phase_d = PH_IDLE;
          end
        end
        PH_ALO_ACK: begin
          if (ev_mak) begin
            load    = 1'b1;
            phase_d = PH_DATA;
          end else if (ev_nomak) begin
            phase_d = PH_IDLE;
          end
        end
        PH_DATA: begin
          if (ev_data)       phase_d = PH_DATA_ACK;
          else if (ev_nomak) phase_d = PH_IDLE;
        end
        PH_DATA_ACK: begin
          if (ev_mak) begin
            inc     = 1'b1;
            phase_d = PH_DATA;
          end else if (ev_nomak) begin
            inc     = 1'b1;
            phase_d = PH_IDLE;
          end
        end
        default: phase_d = PH_IDLE;
      endcase
    end
  end

  // state registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q <= PH_IDLE;
      wr_q    <= 1'b0;
    end else begin
      phase_q <= phase_d;
      wr_q    <= wr_d;
    end
  end

  assign wr_mode = wr_q;

  AST_ACK_NEEDS_BYTE: assert property (@(posedge clk) disable iff (!rst_n)
    inc |-> $past(ev_data) || !$stable(phase_q) || (phase_q == PH_DATA_ACK)) // R3
    else $error("AST_ACK_NEEDS_BYTE");

  AST_IDLE_MAK_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
    (phase_q == PH_IDLE) && ev_mak |-> !inc && !load) // R9
    else $error("AST_IDLE_MAK_IGNORED");

endmodule

// File: rtl/ptr_addr_asm.sv
module ptr_addr_asm #(
  parameter int BYTE_W = 8,
  parameter int ADDR_W = 10
) (
  input  logic              clk,
  input  logic              hi_cap,
  input  logic              lo_cap,
  input  logic [BYTE_W-1:0] byte_in,
  output logic [ADDR_W-1:0] load_val
);

  localparam int HI_W = ADDR_W - BYTE_W;

  logic [HI_W-1:0]   hi_q, hi_d;
  logic [BYTE_W-1:0] lo_q, lo_d;

  always_comb begin
    hi_d = hi_cap ? byte_in[HI_W-1:0] : hi_q;
    lo_d = lo_cap ? byte_in : lo_q;
  end

  always_ff @(posedge clk) begin
    hi_q <= hi_d;
    lo_q <= lo_d;
  end

  assign load_val = {hi_q, lo_q};

endmodule

// File: rtl/ptr_counter.sv
module ptr_counter #(
  parameter int ADDR_W = 10,
  parameter int PAGE_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [ADDR_W-1:0] load_val,
  input  logic              inc,
  input  logic              wr_mode,
  output logic [ADDR_W-1:0] ptr_q,
  output logic              valid_q
);

  logic [ADDR_W-1:0] seq_next, page_next, ptr_d;
  logic              valid_d;
  logic              ptr_en;

  assign seq_next = ptr_q + ADDR_W'(1);

  generate
    if (PAGE_W < ADDR_W) begin : g_page
      logic [PAGE_W-1:0] low_next;
      assign low_next  = ptr_q[PAGE_W-1:0] + PAGE_W'(1);
      assign page_next = {ptr_q[ADDR_W-1:PAGE_W], low_next};

      AST_PAGE_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
        inc && wr_mode |=> ptr_q[ADDR_W-1:PAGE_W] == $past(ptr_q[ADDR_W-1:PAGE_W])) // R5
        else $error("AST_PAGE_KEEP");
    end else begin : g_flat
      assign page_next = seq_next;
    end
  endgenerate

  // next-state logic with explicit enable
  always_comb begin
    ptr_en  = load | inc;
    ptr_d   = ptr_q;
    valid_d = valid_q;
    if (load) begin
      ptr_d   = load_val;
      valid_d = 1'b1;
    end else if (inc) begin
      ptr_d = wr_mode ? page_next : seq_next;
    end
  end

  always_ff @(posedge clk) begin
    if (ptr_en) ptr_q <= ptr_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) valid_q <= 1'b0;
    else        valid_q <= valid_d;
  end

  AST_LOAD_TAKES: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> (ptr_q == $past(load_val)) && valid_q) // R2
    else $error("AST_LOAD_TAKES");

  AST_READ_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    inc && !wr_mode |=> ptr_q == $past(ptr_q) + ADDR_W'(1)) // R4
    else $error("AST_READ_STEP");

  AST_HOLD_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !load && !inc |=> $stable(ptr_q)) // R6
    else $error("AST_HOLD_QUIET");

  AST_VALID_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    valid_q |=> valid_q) // R1
    else $error("AST_VALID_STICKY");

endmodule

// File: rtl/eeprom_addr_ptr.sv
module eeprom_addr_ptr #(
  parameter int ADDR_W = 10,
  parameter int PAGE_W = 4,
  parameter int BYTE_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ev_cmd,
  input  logic [1:0]        cmd_op,
  input  logic              ev_addr,
  input  logic [BYTE_W-1:0] byte_in,
  input  logic              ev_data,
  input  logic              ev_mak,
  input  logic              ev_nomak,
  input  logic              ev_standby,
  output logic [ADDR_W-1:0] arr_addr,
  output logic              addr_valid
);

  logic              hi_cap, lo_cap, load, inc, wr_mode;
  logic [ADDR_W-1:0] load_val;

  ptr_seq u_seq (
    .clk        (clk),
    .rst_n      (rst_n),
    .ev_cmd     (ev_cmd),
    .cmd_op     (cmd_op),
    .ev_addr    (ev_addr),
    .ev_data    (ev_data),
    .ev_mak     (ev_mak),
    .ev_nomak   (ev_nomak),
    .ev_standby (ev_standby),
    .hi_cap     (hi_cap),
    .lo_cap     (lo_cap),
    .load       (load),
    .inc        (inc),
    .wr_mode    (wr_mode)
  );

  ptr_addr_asm #(
    .BYTE_W (BYTE_W),
    .ADDR_W (ADDR_W)
  ) u_asm (
    .clk      (clk),
    .hi_cap   (hi_cap),
    .lo_cap   (lo_cap),
    .byte_in  (byte_in),
    .load_val (load_val)
  );

  ptr_counter #(
    .ADDR_W (ADDR_W),
    .PAGE_W (PAGE_W)
  ) u_cnt (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (load),
    .load_val (load_val),
    .inc      (inc),
    .wr_mode  (wr_mode),
    .ptr_q    (arr_addr),
    .valid_q  (addr_valid)
  );

  AST_ONE_EVENT: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({ev_cmd, ev_addr, ev_data, ev_mak, ev_nomak, ev_standby})) // R9
    else $error("AST_ONE_EVENT");

  AST_STANDBY_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    ev_standby |=> $stable(arr_addr) && $stable(addr_valid)) // R6
    else $error("AST_STANDBY_HOLD");

endmodule

// File: tb/eeprom_addr_ptr_tb_top.sv
module eeprom_addr_ptr_tb_top;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       ev_cmd, ev_addr, ev_data, ev_mak, ev_nomak, ev_standby;
  logic [1:0] cmd_op;
  logic [7:0] byte_in;
  logic [9:0] arr_addr;
  logic       addr_valid;

  int    checks = 0;
  int    failures = 0;
  bit    done = 0;
  string cur_req = "R1";

  always #10 clk = ~clk;

  eeprom_addr_ptr dut_i (
    .clk(clk), .rst_n(rst_n), .ev_cmd(ev_cmd), .cmd_op(cmd_op),
    .ev_addr(ev_addr), .byte_in(byte_in), .ev_data(ev_data),
    .ev_mak(ev_mak), .ev_nomak(ev_nomak), .ev_standby(ev_standby),
    .arr_addr(arr_addr), .addr_valid(addr_valid)
  );

  // behavioural reference: step name, mode, bytes queue
  string m_step;
  bit    m_wr, m_valid;
  int    m_ptr;
  int    m_bytes[$];

  always @(posedge clk) begin
    if (!rst_n) begin
      m_step = "idle"; m_wr = 0; m_valid = 0; m_bytes.delete();
    end else if (ev_standby) begin
      m_step = "idle";
    end else if (ev_cmd) begin
      m_bytes.delete();
      m_wr = (cmd_op == 2'd2);
      if (cmd_op == 2'd1 || cmd_op == 2'd2) m_step = "addr";
      else if (cmd_op == 2'd3) m_step = "data";
      else m_step = "idle";
    end else if (m_step == "addr") begin
      if (ev_addr) begin m_bytes.push_back(int'(byte_in)); m_step = "addr_ack"; end
      else if (ev_nomak) m_step = "idle";
    end else if (m_step == "addr_ack") begin
      if (ev_mak) begin
        if (m_bytes.size() == 2) begin
          m_ptr = (m_bytes[0] * 256 + m_bytes[1]) % 1024;
          m_valid = 1; m_step = "data";
        end else m_step = "addr";
      end else if (ev_nomak) m_step = "idle";
    end else if (m_step == "data") begin
      if (ev_data) m_step = "data_ack";
      else if (ev_nomak) m_step = "idle";
    end else if (m_step == "data_ack") begin
      if (ev_mak || ev_nomak) begin
        if (m_wr) m_ptr = (m_ptr / 16) * 16 + ((m_ptr % 16) + 1) % 16;
        else      m_ptr = (m_ptr + 1) % 1024;
        m_step = ev_mak ? "data" : "idle";
      end
    end
  end

  // compare on every falling edge
  always @(negedge clk) begin
    if (rst_n && !done) begin
      checks++;
      if (addr_valid !== m_valid || (m_valid && arr_addr !== 10'(m_ptr))) begin
        failures++;
        $display("FAIL %s: valid=%0b addr=%0d expected valid=%0b addr=%0d",
                 cur_req, addr_valid, arr_addr, m_valid, m_ptr);
      end
    end
  end

  task automatic clr();
    ev_cmd = 0; ev_addr = 0; ev_data = 0; ev_mak = 0; ev_nomak = 0; ev_standby = 0;
  endtask

  task automatic cmd(input logic [1:0] op);
    @(negedge clk); ev_cmd = 1; cmd_op = op; @(negedge clk); clr();
  endtask
  task automatic addr_b(input logic [7:0] b);
    @(negedge clk); ev_addr = 1; byte_in = b; @(negedge clk); clr();
  endtask
  task automatic dbyte();   @(negedge clk); ev_data = 1;    @(negedge clk); clr(); endtask
  task automatic mak();     @(negedge clk); ev_mak = 1;     @(negedge clk); clr(); endtask
  task automatic nomak();   @(negedge clk); ev_nomak = 1;   @(negedge clk); clr(); endtask
  task automatic standby(); @(negedge clk); ev_standby = 1; @(negedge clk); clr(); endtask

  task automatic expect_ptr(input bit v, input int a, input string tag);
    checks++;
    if (addr_valid !== v || (v && arr_addr !== 10'(a))) begin
      failures++;
      $display("FAIL %s: valid=%0b addr=%0d expected valid=%0b addr=%0d",
               tag, addr_valid, arr_addr, v, a);
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1; failures++;
      $display("FAIL watchdog: run did not complete, expected completion");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    clr(); cmd_op = 0; byte_in = 0; rst_n = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    expect_ptr(0, 0, "R1");

    cur_req = "R9";
    mak(); standby(); nomak();
    expect_ptr(0, 0, "R9");

    cur_req = "R2";
    cmd(2'b01); addr_b(8'h3F); mak();
    expect_ptr(0, 0, "R2");
    addr_b(8'hFE); mak();
    expect_ptr(1, 1022, "R2");

    cur_req = "R4";
    dbyte(); mak(); expect_ptr(1, 1023, "R3");
    dbyte(); mak(); expect_ptr(1, 0, "R4");
    dbyte(); nomak(); expect_ptr(1, 1, "R3");

    cur_req = "R8";
    dbyte(); mak(); dbyte(); nomak();
    expect_ptr(1, 1, "R8");

    cur_req = "R5";
    cmd(2'b10); addr_b(8'h01); mak(); addr_b(8'h2E); mak();
    expect_ptr(1, 302, "R2");
    dbyte(); mak(); expect_ptr(1, 303, "R5");
    dbyte(); mak(); expect_ptr(1, 288, "R5");
    dbyte(); mak(); expect_ptr(1, 289, "R5");

    cur_req = "R6";
    dbyte(); standby(); expect_ptr(1, 289, "R6");
    mak(); expect_ptr(1, 289, "R6");

    cur_req = "R7";
    cmd(2'b11); dbyte(); mak(); expect_ptr(1, 290, "R7");
    dbyte(); nomak(); expect_ptr(1, 291, "R7");

    cur_req = "R9";
    cmd(2'b00); addr_b(8'h00); mak(); addr_b(8'h00); mak();
    dbyte(); mak();
    expect_ptr(1, 291, "R9");

    cur_req = "R2";
    cmd(2'b01); addr_b(8'hFC); mak(); addr_b(8'h05); mak();
    expect_ptr(1, 5, "R2");
    cmd(2'b01); addr_b(8'h02); nomak(); addr_b(8'h10); mak();
    expect_ptr(1, 5, "R9");

    repeat (2) @(negedge clk);
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule